// File: doc/BRIEF.md
# Single-PHY Packet Receive Source with Throttled Byte Output

This block is the PHY-side driver for the receive direction of a byte-wide, single-port packet interface. It draws packet bytes from an internal ready/valid stream that carries start, end and error markers. On each rising edge of the interface clock it presents one byte on the output bus with a valid strobe, a start flag, an end flag, an error flag and an odd parity bit.

The link layer throttles the block with an active-low enable input. A change on that input reaches the bus on the second rising edge after the change, for both stopping and restarting. One sampling register holds the enable, and the output register launches the byte. While the enable is held off, or while the stream has nothing to offer, the valid strobe stays low and the data bus keeps its last byte.

Port-selection cycles, in-band address cycles and byte-count signalling for partial words are not generated.

Top module: `spl_rx_source`

## Requirements
- R1: After synchronous reset, the valid, start, end and error outputs are low, the data bus is 0x00, the parity output is 1, and stream ready is low.
- R2: The start flag is high together with the first byte of each packet and is low on every other presented byte.
- R3: Bytes leave in stream order, each exactly once. The end flag is high only on the last byte of a packet. No byte is lost or duplicated across pauses.
- R4: When the stream offers no byte, valid is low on the next edge and the data bus holds the last presented byte.
- R5: If the enable input goes high (off) between two edges, the byte launched on the first edge after the change is still presented, and valid is low from the second edge on.
- R6: If the enable input returns low between two edges, valid is low after the first edge and the next byte is presented on the second edge.
- R7: The parity output makes the count of ones across the data bus and the parity bit odd on every cycle.
- R8: The error output is high only on an end-of-packet byte whose error marker is set. Error markers on non-final bytes have no effect on the error output.
- R9: Stream ready goes high on the first edge after the enable input is sampled low, and goes low on the first edge after it is sampled high. The stream is consumed only on handshake cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Internal stream has a byte |
| s_ready | output | 1 | Block accepts the stream byte this cycle |
| s_data | input | 8 | Stream byte |
| s_sop | input | 1 | Stream byte is first of a packet |
| s_eop | input | 1 | Stream byte is last of a packet |
| s_err | input | 1 | Error marker carried with the stream byte |
| lnk_enable_n_i | input | 1 | Link-layer throttle, active low |
| lnk_data_o | output | 8 | Presented byte |
| lnk_par_o | output | 1 | Odd parity over the presented byte |
| lnk_sop_o | output | 1 | Start-of-packet flag |
| lnk_eop_o | output | 1 | End-of-packet flag |
| lnk_err_o | output | 1 | Packet error flag, end byte only |
| lnk_valid_o | output | 1 | Presented byte is valid |

## Verification
A wrong enable-sampling state shows up one edge early or late at the valid strobe, on the edge that a halt or resume should hit. A fault in the pop handshake shows up as a repeated or missing byte in the captured packet. A fault in the output register shows up as a parity or hold violation on the first idle cycle after it. A stale framing flag shows up as a start or end flag on the wrong byte, within the same packet.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    localparam int BUS_W = 8;

    typedef struct packed {
        logic [BUS_W-1:0] data;
        logic             par;
        logic             sop;
        logic             eop;
        logic             err;
    } beat_t;

    function automatic logic odd_par(input logic [BUS_W-1:0] d);
        return ~(^d);
    endfunction

    localparam beat_t BEAT_RESET = '{data: '0, par: 1'b1, sop: 1'b0, eop: 1'b0, err: 1'b0};

endpackage

// File: rtl/rxs_enable_sampler.sv
module rxs_enable_sampler (
    input  logic clk,
    input  logic rst,
    input  logic enable_n,
    output logic go
);
    logic go_q;

    always_ff @(posedge clk) begin
        if (rst) go_q <= 1'b0;
        else     go_q <= ~enable_n;
    end

    assign go = go_q;

    AST_GO_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (go == !$past(enable_n)));  // R9
endmodule

// File: rtl/rxs_beat_former.sv
module rxs_beat_former
    import rxs_pkg::*;
(
    input  logic [BUS_W-1:0] data,
    input  logic             sop,
    input  logic             eop,
    input  logic             err,
    output beat_t            beat
);
    always_comb begin
        beat.data = data;
        beat.par  = odd_par(data);
        beat.sop  = sop;
        beat.eop  = eop;
        beat.err  = eop & err;
    end
endmodule

// File: rtl/rxs_out_stage.sv
module rxs_out_stage
    import rxs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take,
    input  beat_t nb,
    output beat_t q_beat,
    output logic  q_vld
);
    beat_t beat_r;
    logic  vld_r;
    logic  in_pkt;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_r <= BEAT_RESET;
            vld_r  <= 1'b0;
        end else if (take) begin
            beat_r <= nb;
            vld_r  <= 1'b1;
        end else begin
            vld_r      <= 1'b0;
            beat_r.sop <= 1'b0;
            beat_r.eop <= 1'b0;
            beat_r.err <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) in_pkt <= 1'b0;
        else if (vld_r && beat_r.eop) in_pkt <= 1'b0;
        else if (vld_r && beat_r.sop) in_pkt <= 1'b1;
    end

    assign q_beat = beat_r;
    assign q_vld  = vld_r;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(beat_r.data) && !vld_r);  // R4
    AST_SOP_FRESH: assert property (@(posedge clk) disable iff (rst)
        (vld_r && beat_r.sop) |-> !in_pkt);  // R2
    AST_FLAG_NEEDS_VLD: assert property (@(posedge clk) disable iff (rst)
        (beat_r.sop || beat_r.eop || beat_r.err) |-> vld_r);  // R3
endmodule

// File: rtl/spl_rx_source.sv
module spl_rx_source
    import rxs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             s_valid,
    output logic             s_ready,
    input  logic [BUS_W-1:0] s_data,
    input  logic             s_sop,
    input  logic             s_eop,
    input  logic             s_err,
    input  logic             lnk_enable_n_i,
    output logic [BUS_W-1:0] lnk_data_o,
    output logic             lnk_par_o,
    output logic             lnk_sop_o,
    output logic             lnk_eop_o,
    output logic             lnk_err_o,
    output logic             lnk_valid_o
);
    logic  go;
    logic  take;
    beat_t nb;
    beat_t ob;
    logic  ov;

    rxs_enable_sampler u_sampler (
        .clk      (clk),
        .rst      (rst),
        .enable_n (lnk_enable_n_i),
        .go       (go)
    );

    rxs_beat_former u_former (
        .data (s_data),
        .sop  (s_sop),
        .eop  (s_eop),
        .err  (s_err),
        .beat (nb)
    );

    assign take = go & s_valid;

    rxs_out_stage u_out (
        .clk    (clk),
        .rst    (rst),
        .take   (take),
        .nb     (nb),
        .q_beat (ob),
        .q_vld  (ov)
    );

    assign s_ready     = go;
    assign lnk_data_o  = ob.data;
    assign lnk_par_o   = ob.par;
    assign lnk_sop_o   = ob.sop;
    assign lnk_eop_o   = ob.eop;
    assign lnk_err_o   = ob.err;
    assign lnk_valid_o = ov;

    AST_HALT_LATENCY: assert property (@(posedge clk) disable iff (rst)
        lnk_valid_o |-> !$past(lnk_enable_n_i, 2));  // R5
    AST_RESUME_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst, 2) && !$past(rst) && !$past(lnk_enable_n_i, 2) && $past(s_valid)) |-> lnk_valid_o);  // R6
    AST_ODD_PARITY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (^{lnk_data_o, lnk_par_o}) == 1'b1);  // R7
    AST_ERR_ON_END: assert property (@(posedge clk) disable iff (rst)
        lnk_err_o |-> (lnk_eop_o && lnk_valid_o));  // R8
    AST_POP_PRESENTS: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_ready) |=> (lnk_valid_o && lnk_data_o == $past(s_data)));  // R3
endmodule

// File: tb/test_spl_rx_source.sv
module test_spl_rx_source;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       s_valid, s_ready, s_sop, s_eop, s_err;
    logic [7:0] s_data;
    logic       en_n = 1'b1;
    logic [7:0] o_data;
    logic       o_par, o_sop, o_eop, o_err, o_vld;

    always #2 clk = ~clk;

    logic [7:0] m_data [256];
    logic       m_sop [256];
    logic       m_eop [256];
    logic       m_err [256];
    int         wr_cnt = 0;
    int         rd_idx = 0;
    logic       src_on = 1'b0;

    logic [7:0] c_data [256];
    logic       c_sop [256];
    logic       c_eop [256];
    logic       c_err [256];
    int         cap_n = 0;
    int         par_bad = 0;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;

    assign s_valid = src_on && (rd_idx < wr_cnt);
    assign s_data  = m_data[rd_idx[7:0]];
    assign s_sop   = m_sop[rd_idx[7:0]];
    assign s_eop   = m_eop[rd_idx[7:0]];
    assign s_err   = m_err[rd_idx[7:0]];

    spl_rx_source i_spl_rx_source (
        .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .s_sop(s_sop), .s_eop(s_eop), .s_err(s_err),
        .lnk_enable_n_i(en_n), .lnk_data_o(o_data), .lnk_par_o(o_par),
        .lnk_sop_o(o_sop), .lnk_eop_o(o_eop), .lnk_err_o(o_err), .lnk_valid_o(o_vld)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst && s_valid && s_ready) rd_idx <= rd_idx + 1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if ((^{o_data, o_par}) != 1'b1) par_bad = par_bad + 1;
            if (o_vld) begin
                c_data[cap_n] = o_data; c_sop[cap_n] = o_sop;
                c_eop[cap_n]  = o_eop;  c_err[cap_n] = o_err;
                cap_n = cap_n + 1;
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        wait (cyc > 100000);
        fails = fails + 1;
        $display("FAIL watchdog: actual cycles=%0d expected < 100000", cyc);
        summary();
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors = vectors + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic load_pkt(input int len, input int seed, input bit err_last, input bit err_mid);
        for (int i = 0; i < len; i++) begin
            m_data[wr_cnt+i] = 8'((seed + i * 37) & 255);
            m_sop[wr_cnt+i]  = (i == 0);
            m_eop[wr_cnt+i]  = (i == len - 1);
            m_err[wr_cnt+i]  = (i == len - 1) ? err_last : (err_mid && i == 0);
        end
        wr_cnt = wr_cnt + len;
    endtask

    task automatic drain();
        for (int i = 0; i < 600; i++) begin
            if (rd_idx == wr_cnt && !o_vld) break;
            step();
        end
        step();
    endtask

    task automatic verify(input int first, input int len, input string req);
        bit ok = (cap_n >= first + len);
        chk(ok, {req, " byte count"}, cap_n - first, len);
        if (ok) begin
            int bad = 0;
            for (int k = first; k < first + len; k++) begin
                if (c_data[k] !== m_data[k] || c_sop[k] !== m_sop[k] || c_eop[k] !== m_eop[k]
                    || c_err[k] !== (m_eop[k] & m_err[k])) bad = bad + 1;
            end
            chk(bad == 0, {req, " beat content"}, bad, 0);
        end
    endtask

    task automatic t_reset();
        chk(o_vld == 0 && o_sop == 0 && o_eop == 0 && o_err == 0, "R1 flags", {o_vld, o_sop, o_eop, o_err}, 0);
        chk(o_data == 8'h00, "R1 data", o_data, 0);
        chk(o_par == 1'b1, "R1 parity", o_par, 1);
        chk(s_ready == 1'b0, "R1 ready", s_ready, 0);
    endtask

    task automatic t_ready_resume();
        int first = wr_cnt;
        int idx0;
        load_pkt(5, 3, 1'b0, 1'b0);
        src_on = 1'b1;
        step(); step();
        idx0 = rd_idx;
        chk(s_ready == 0 && o_vld == 0 && idx0 == first, "R9 held off", {s_ready, o_vld}, 0);
        en_n = 1'b0;
        step();
        chk(s_ready == 1'b1, "R9 ready after one edge", s_ready, 1);
        chk(o_vld == 1'b0, "R6 idle after first edge", o_vld, 0);
        step();
        chk(o_vld == 1'b1 && o_sop == 1'b1, "R6 present on second edge", {o_vld, o_sop}, 3);
        chk(o_data == m_data[first], "R2 first byte", o_data, m_data[first]);
        drain();
        verify(first, 5, "R3 short packet");
    endtask

    task automatic t_packets();
        int first = wr_cnt;
        load_pkt(1, 200, 1'b1, 1'b0);
        load_pkt(7, 11, 1'b0, 1'b1);
        load_pkt(4, 90, 1'b1, 1'b1);
        drain();
        verify(first, 1, "R2 single byte sop+eop");
        verify(first, 1, "R8 err on single byte");
        verify(first + 1, 7, "R8 mid err ignored");
        verify(first + 8, 4, "R3 back-to-back");
    endtask

    task automatic t_gap();
        int first = wr_cnt;
        logic [7:0] last;
        load_pkt(8, 55, 1'b0, 1'b0);
        step(); step(); step();
        src_on = 1'b0;
        step(); step();
        last = c_data[cap_n-1];
        chk(o_vld == 1'b0, "R4 valid low when empty", o_vld, 0);
        chk(o_data == last, "R4 data holds", o_data, last);
        step();
        chk(o_data == last && o_sop == 0 && o_eop == 0, "R4 still holding", o_data, last);
        src_on = 1'b1;
        drain();
        verify(first, 8, "R3 across stream gap");
    endtask

    task automatic t_halt();
        int first = wr_cnt;
        int hold_cap;
        load_pkt(40, 7, 1'b1, 1'b0);
        step(); step(); step(); step();
        chk(o_vld == 1'b1, "R5 running before halt", o_vld, 1);
        en_n = 1'b1;
        step();
        chk(o_vld == 1'b1, "R5 first edge still presents", o_vld, 1);
        step();
        chk(o_vld == 1'b0, "R5 halted on second edge", o_vld, 0);
        hold_cap = cap_n;
        step(); step(); step();
        chk(o_vld == 1'b0 && cap_n == hold_cap, "R5 stays halted", cap_n - hold_cap, 0);
        en_n = 1'b0;
        step();
        chk(o_vld == 1'b0, "R6 idle after first edge", o_vld, 0);
        step();
        chk(o_vld == 1'b1, "R6 resumes on second edge", o_vld, 1);
        chk(o_data == m_data[hold_cap], "R3 resumes with next byte", o_data, m_data[hold_cap]);
        step();
        en_n = 1'b1; step(); en_n = 1'b0; step(); step();
        drain();
        verify(first, 40, "R3 no loss across pauses");
        chk(s_ready == 1'b1, "R9 ready while enabled", s_ready, 1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            m_data[i] = 0; m_sop[i] = 0; m_eop[i] = 0; m_err[i] = 0;
        end
        step(); step();
        t_reset();
        rst = 1'b0;
        step();
        t_reset();
        t_ready_resume();
        t_packets();
        t_gap();
        t_halt();
        chk(par_bad == 0, "R7 odd parity every cycle", par_bad, 0);
        chk(o_par == ~(^o_data), "R7 parity at end", o_par, ~(^o_data));
        summary();
    end
endmodule